// File: doc/BRIEF.md
# Random Integer to Unit-Interval Float Converter

This block turns a 32-bit unsigned integer, usually a word from a pseudo-random generator, into the bit pattern of an IEEE-754 single-precision number. The number equals the integer scaled by 2^-32, so every result lies in [0,1). It does this without a floating-point multiplier. Because the scale factor is a power of two, the work reduces to three steps:

- count the leading zeros of the integer;
- shift the integer left until its top bit is set;
- build the exponent from the zero count, with the scale factor already folded into that subtraction.

The fraction field takes the 23 bits that follow the leading one. The bits below them are dropped rather than rounded. An all-zero input bypasses the arithmetic and yields +0.0.

The block is a two-stage pipeline. One stage registers the incoming integer. The second stage registers the assembled float after the leading-zero count and the normalizing shifter. A new integer can be presented on every clock cycle. Each result appears with its own valid flag a fixed two cycles later.

Top module: `u2f_unit_float`

## Requirements
- R1: For a nonzero input x whose highest set bit is at position p, the output is {sign=0, exponent field (bits 30:23) = 95 + p, fraction field (bits 22:0) = the 23 bits of x directly below bit p}, with zeros filling positions below bit 0. This is x·2^-32 truncated to 24 significant bits.
- R2: An input of 0x00000000 produces the output pattern 0x00000000 (+0.0).
- R3: An input of 0x00000001 produces 0x2F800000 (2^-32).
- R4: An input of 0xFFFFFFFF produces 0x3F7FFFFF, the largest single-precision value below 1.0.
- R5: Bit 31 (sign) of every valid output is 0, and every valid output is below 0x3F800000.
- R6: The exponent field of a valid output is zero only when the input was zero.
- R7: Input bits more than 23 positions below the highest set bit have no effect on the output (truncation, no rounding).
- R8: out_valid is high exactly two clock cycles after the cycle in which in_valid was sampled high, and low otherwise; out_data belongs to that input.
- R9: Inputs presented on consecutive cycles are all accepted, and their results emerge on consecutive cycles in the same order.
- R10: While rst_n is low at a clock edge, out_valid and out_data are cleared to 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is present this cycle |
| in_word | input | 32 | Unsigned integer to convert |
| out_valid | output | 1 | Result is present this cycle |
| out_data | output | 32 | Single-precision bit pattern of in_word·2^-32 |

## Verification
A word sampled on one rising edge is held in the first register stage after that edge. Its result is in the output register after the next edge. The bench therefore drives each input on a falling edge and compares the outputs two falling edges later, against a history of what it drove. The valid flag is checked on every such cycle, including gap cycles, so an early, late or lost result is caught as a mismatch in the cycle it should have appeared. Expected patterns come from locating the highest set bit arithmetically. The sweeps cover every power of two, every all-ones run, long back-to-back random streams, and pairs that differ only in discarded bits.

// File: rtl/u2f_pkg.sv
// Package u2f_pkg
// Shared default sizes for the integer-to-float converter.
// Assumes a binary32-shaped target: 1 sign bit, 8 exponent bits, 23 fraction bits.
package u2f_pkg;
    localparam int U2F_IN_W   = 32;   // width of the unsigned integer input
    localparam int U2F_EXP_W  = 8;    // exponent field width
    localparam int U2F_FRAC_W = 23;   // stored fraction width
    localparam int U2F_BIAS   = 127;  // exponent bias
endpackage

// File: rtl/u2f_lzc.sv
// Module u2f_lzc
// Combinational priority encoder that gives the number of leading zero bits of
// a word. The count runs from 0 to W, and an all-zero word gives W.
// Assumes W is a power of two.
module u2f_lzc #(
    parameter int W  = 32,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  word,
    output logic [CW-1:0] count
);
    // Scan upward so that the highest set bit decides the count.
    always_comb begin
        count = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (word[i]) count = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/u2f_norm_shift.sv
// Module u2f_norm_shift
// Logarithmic left shifter. Stage k shifts by 2^(SW-1-k) when the matching bit
// of amt is set, so the largest step comes first.
// Assumes amt is at most W-1.
module u2f_norm_shift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  word_in,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  word_out
);
    logic [W-1:0] stg [0:SW];

    assign stg[0] = word_in;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int BIT  = SW - 1 - k;
        localparam int STEP = 1 << BIT;
        // One conditional shift by a fixed power of two.
        assign stg[k+1] = amt[BIT] ? (stg[k] << STEP) : stg[k];
    end

    assign word_out = stg[SW];
endmodule

// File: rtl/u2f_unit_float.sv
// Module u2f_unit_float
// Converts an unsigned integer x into the floating-point pattern of x * 2^-IN_W.
// Pipeline: stage 1 registers the input. Stage 2 registers the float built from
// the leading-zero count, the normalizing shift and the exponent assembly.
// Latency is two cycles, and a new input is accepted on every cycle.
// Assumes BIAS-1 >= IN_W, so no result is denormal, and IN_W-1 >= FRAC_W.
module u2f_unit_float
    import u2f_pkg::*;
#(
    parameter int IN_W   = U2F_IN_W,
    parameter int EXP_W  = U2F_EXP_W,
    parameter int FRAC_W = U2F_FRAC_W,
    parameter int BIAS   = U2F_BIAS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [IN_W-1:0]           in_word,
    output logic                      out_valid,
    output logic [EXP_W+FRAC_W:0]     out_data
);
    localparam int SW    = $clog2(IN_W);
    localparam int CW    = SW + 1;
    localparam int OUT_W = EXP_W + FRAC_W + 1;

    logic              s1_valid;
    logic [IN_W-1:0]   s1_word;
    logic [CW-1:0]     lz;
    logic [IN_W-1:0]   norm;
    logic              is_zero;
    logic [EXP_W-1:0]  exp_fld;
    logic [FRAC_W-1:0] frac_fld;

    // Stage 1: capture the incoming integer and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_word  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_word  <= in_word;
        end
    end

    u2f_lzc #(.W(IN_W), .CW(CW)) u_lzc (
        .word  (s1_word),
        .count (lz)
    );

    u2f_norm_shift #(.W(IN_W), .SW(SW)) u_shift (
        .word_in  (s1_word),
        .amt      (lz[SW-1:0]),
        .word_out (norm)
    );

    // The top count bit is set only for an all-zero word.
    assign is_zero = lz[SW];

    // Exponent folds the normalization and the 2^-IN_W scale into one subtraction.
    always_comb begin
        exp_fld  = is_zero ? '0 : (EXP_W'(BIAS - 1) - EXP_W'(lz));
        frac_fld = is_zero ? '0 : norm[IN_W-2 -: FRAC_W];
    end

    // Stage 2: register the assembled float with its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            out_data  <= {1'b0, exp_fld, frac_fld};
        end
    end

    // R1: a nonzero staged word is normalized so that its top bit is set.
    p_norm_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_word != '0) |-> norm[IN_W-1]);

    // R2: a zero staged word gives +0.0 on the next cycle.
    p_zero_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_word == '0) |=> (out_data == '0));

    // R5: a valid output has a clear sign bit and stays below 1.0.
    p_sign_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!out_data[OUT_W-1] && out_data < OUT_W'({1'b0, EXP_W'(BIAS), FRAC_W'(0)})));

    // R6: a nonzero staged word never yields a zero exponent field.
    p_exp_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_word != '0) |=> (out_data[OUT_W-2 -: EXP_W] != '0));

    // R8: the valid flag emerges exactly two cycles after the input valid.
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (out_valid == $past(in_valid, 2)));
endmodule

// File: tb/sim_u2f_unit_float.sv
// Bench for u2f_unit_float. Inputs are driven on falling edges. Outputs are
// checked two falling edges later against values computed from the requirements.
module sim_u2f_unit_float;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int errors = 0;

    logic        h1v = 1'b0, h2v = 1'b0;
    logic [31:0] h1d = '0, h2d = '0;
    string       h1t = "R1", h2t = "R1";
    logic        armed = 1'b0;
    logic [31:0] lfsr = 32'h1234_5679;

    always #5 clk = ~clk;

    u2f_unit_float u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Expected pattern: exponent 95 + msb position, then the next 23 bits.
    function automatic logic [31:0] expect_of(input logic [31:0] x);
        int p = 0;
        logic [31:0] sh;
        if (x == 0) return 32'h0;
        for (int i = 0; i < 32; i++) if (x[i]) p = i;
        sh = x << (31 - p);
        return {1'b0, 8'(95 + p), sh[30:8]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: check the result due now, then drive the next input.
    task automatic step(input logic v, input logic [31:0] d, input string tag);
        @(negedge clk);
        if (armed) begin
            check((h2v && h1v) ? "R9" : "R8", {31'b0, out_valid}, {31'b0, h2v});
            if (h2v) begin
                check(h2t, out_data, expect_of(h2d));
                check("R5", {31'b0, out_data[31]}, 32'h0);
                if (h2d != 0)
                    check("R6", {31'b0, (out_data[30:23] == 8'h0)}, 32'h0);
            end
        end
        h2v = h1v; h2d = h1d; h2t = h1t;
        h1v = v;   h1d = d;   h1t = tag;
        in_valid = v;
        in_word  = d;
        armed = 1'b1;
    endtask

    function automatic string tag_of(input logic [31:0] x);
        if (x == 32'h0) return "R2";
        if (x == 32'h1) return "R3";
        if (x == 32'hFFFF_FFFF) return "R4";
        return "R1";
    endfunction

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R10: outputs are cleared while reset is held.
        repeat (3) @(negedge clk);
        check("R10", {31'b0, out_valid}, 32'h0);
        check("R10", out_data, 32'h0);
        rst_n = 1'b1;

        // Boundary values: zero, one, all ones.
        step(1'b1, 32'h0, "R2");
        step(1'b0, 32'h0, "R8");
        step(1'b1, 32'h1, "R3");
        step(1'b0, 32'h0, "R8");
        step(1'b1, 32'hFFFF_FFFF, "R4");
        step(1'b0, 32'h0, "R8");
        step(1'b0, 32'h0, "R8");

        // Every power of two and every run of ones, back to back.
        for (int k = 0; k < 32; k++) begin
            step(1'b1, 32'h1 << k, tag_of(32'h1 << k));
            step(1'b1, (32'h2 << k) - 32'h1, tag_of((32'h2 << k) - 32'h1));
        end

        // R7: the discarded low bits do not change the result.
        for (int k = 24; k < 32; k++) begin
            logic [31:0] base = (32'h1 << k) | 32'h00A5_5A00;
            step(1'b1, base & ~((32'h1 << (k - 23)) - 32'h1), "R7");
            step(1'b1, base | ((32'h1 << (k - 23)) - 32'h1), "R7");
        end

        // R8: valid with irregular gaps.
        for (int n = 0; n < 200; n++) begin
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            step(lfsr[3] | lfsr[9], lfsr >> (lfsr[4:0]), "R8");
        end

        // R9: a long back-to-back random stream.
        for (int n = 0; n < 20000; n++) begin
            lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
            step(1'b1, lfsr, "R9");
        end

        // Drain the pipeline so the last results are checked.
        step(1'b0, 32'h0, "R8");
        step(1'b0, 32'h0, "R8");
        step(1'b0, 32'h0, "R8");

        // R10: a reset in mid-stream clears the output.
        in_valid = 1'b1;
        in_word  = 32'hDEAD_BEEF;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", {31'b0, out_valid}, 32'h0);
        check("R10", out_data, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule